// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Atomic Bit Aliases

This block is a general-purpose I/O controller for a parameterised number of 32-pin banks behind a single-cycle register port: an address, a write enable, write data and combinational read data. Each bank has an output-data register, an output-enable register, a read-only view of the synchronized pin levels and a set of per-pin interrupt controls. These are an interrupt-select mask, an interrupt-enable mask, two mode planes (level and polarity) and a sticky status register. Each bank drives one interrupt line.

Every writable register answers at four alias addresses: plain write, bit set, bit clear and bit toggle. Software can therefore change single pins without a read-modify-write sequence. A read at any alias returns the register itself. Pin inputs pass through a two-flop synchronizer, and the interrupt detector works on the synchronized samples.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every register is zero, so `pin_out`, `pin_oe` and `irq` are all zero.
- R2: Address decoding is as follows. Bits [11:8] select the region: 0 output data, 1 input data, 2 output enable, 3 interrupt select, 4 interrupt enable, 5 status, 6 level mode, 7 polarity mode. Bits [7:4] select the bank, so banks are 0x10 apart. Bits [3:2] select the alias: 0 write, 1 set, 2 clear, 3 toggle. A read at any alias returns the register's value.
- R3: A write to the set alias ORs the write data into the register.
- R4: A write to the clear alias clears each register bit whose write-data bit is one.
- R5: A write to the toggle alias inverts each register bit whose write-data bit is one.
- R6: `pin_out` and `pin_oe` carry the output-data and output-enable registers of each bank. Bank b occupies bits [32b+31:32b], and a one in `pin_oe` marks an output. Without a write, both hold their value.
- R7: A read of the input-data region returns the pin levels after a two-flop synchronizer. A level change on `pin_in` that is set up before clock edge k is readable after edge k+1. Writes to this region are ignored.
- R8: A pin's mode is {polarity, level}, taken from the polarity and level planes: 0 falling edge, 1 low level, 2 rising edge, 3 high level. An edge is a difference between the two newest synchronized samples. A matching condition sets the pin's status bit one edge later, so a pin change set up before edge k shows in status after edge k+2.
- R9: In level mode, the status bit is set again on every cycle that the level persists. When a clear write and a detected condition fall in the same cycle, the bit stays set.
- R10: A status bit can be set only while its interrupt-select bit is one. Status is cleared only by ones written to its clear alias. Writes to the status register's write, set and toggle aliases are ignored.
- R11: `irq[b]` is the OR of bank b's status bits ANDed with its interrupt-enable bits.
- R12: An address whose bank field is at least NUM_BANKS, or whose region field is above 7, reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | NUM_BANKS*32 | Asynchronous pin levels |
| pin_out | output | NUM_BANKS*32 | Output-data register contents |
| pin_oe | output | NUM_BANKS*32 | Output-enable register contents |
| irq | output | NUM_BANKS | Per-bank interrupt |

## Verification
The two functions that can meet in one cycle are a status-clear write and a status set by the detector. With a high-level pin held, the bench writes ones to the status clear alias while the level persists. It then reads status back and expects the bit still set, because detection takes priority over clearing. After the pin drops and the synchronizer drains, the same clear is expected to take effect. A second case changes an interrupt-enable bit through the set alias while a status bit is already pending, and the bench expects the bank interrupt to follow in the same cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int PINS         = 32;
   localparam int ALIAS_LSB    = 2;
   localparam int BANK_LSB     = 4;
   localparam int BANK_FIELD_W = 4;
   localparam int REGION_LSB   = 8;
   localparam int REGION_W     = 4;
   localparam int MIN_ADDR_W   = REGION_LSB + REGION_W;

   localparam logic [REGION_W-1:0] RG_OUT  = 4'd0;
   localparam logic [REGION_W-1:0] RG_IN   = 4'd1;
   localparam logic [REGION_W-1:0] RG_OE   = 4'd2;
   localparam logic [REGION_W-1:0] RG_SEL  = 4'd3;
   localparam logic [REGION_W-1:0] RG_IEN  = 4'd4;
   localparam logic [REGION_W-1:0] RG_STAT = 4'd5;
   localparam logic [REGION_W-1:0] RG_LVL  = 4'd6;
   localparam logic [REGION_W-1:0] RG_POL  = 4'd7;
   localparam logic [REGION_W-1:0] RG_LAST = RG_POL;

   typedef enum logic [1:0] {
      AL_WRITE = 2'd0,
      AL_SET   = 2'd1,
      AL_CLR   = 2'd2,
      AL_TOG   = 2'd3
   } alias_e;

   function automatic logic [PINS-1:0] apply_alias(input alias_e al,
                                                   input logic [PINS-1:0] cur,
                                                   input logic [PINS-1:0] wd);
      logic [PINS-1:0] nxt;
      case (al)
         AL_WRITE: nxt = wd;
         AL_SET:   nxt = cur | wd;
         AL_CLR:   nxt = cur & ~wd;
         default:  nxt = cur ^ wd;
      endcase
      return nxt;
   endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int ADDR_W    = 12,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [REGION_W-1:0] region,
   output logic [BANK_W-1:0]   bank,
   output alias_e              alias_sel,
   output logic                hit
);
   logic [BANK_FIELD_W-1:0] bank_field;
   logic                    upper_zero;

   assign region     = addr[REGION_LSB +: REGION_W];
   assign bank_field = addr[BANK_LSB +: BANK_FIELD_W];
   assign bank       = bank_field[BANK_W-1:0];
   assign alias_sel  = alias_e'(addr[ALIAS_LSB +: 2]);

   generate
      if (ADDR_W > MIN_ADDR_W) begin : g_upper
         assign upper_zero = (addr[ADDR_W-1:MIN_ADDR_W] == '0);
      end else begin : g_no_upper
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign hit = upper_zero
              && (region <= RG_LAST)
              && ({28'd0, bank_field} < 32'(NUM_BANKS));
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
   import gpio_pkg::*;
#(
   parameter int               W         = 32,
   parameter logic [W-1:0]     RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  alias_e       alias_sel,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   generate
      if (W != PINS) begin : g_bad_width
         $error("gpio_alias_reg: W must equal the pin count per bank");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         q <= RESET_VAL;
      else if (we)
         q <= apply_alias(alias_sel, q, wdata);
   end
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq
   import gpio_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PINS-1:0] pin_in,
   input  logic [PINS-1:0] sel,
   input  logic [PINS-1:0] lvl,
   input  logic [PINS-1:0] pol,
   input  logic            clr_we,
   input  logic [PINS-1:0] clr_mask,
   output logic [PINS-1:0] level,
   output logic [PINS-1:0] stat
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_pin_irq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [PINS-1:0] chain [SYNC_STAGES];
   logic [PINS-1:0] prev;
   logic [PINS-1:0] rise, fall, cond;

   always_ff @(posedge clk) begin
      if (rst) chain[0] <= '0;
      else     chain[0] <= pin_in;
   end

   generate
      for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign level = chain[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (rst) prev <= '0;
      else     prev <= level;
   end

   assign rise = level & ~prev;
   assign fall = ~level & prev;

   generate
      for (genvar p = 0; p < PINS; p++) begin : g_mode
         always_comb begin
            case ({pol[p], lvl[p]})
               2'b00:   cond[p] = fall[p];
               2'b01:   cond[p] = ~level[p];
               2'b10:   cond[p] = rise[p];
               default: cond[p] = level[p];
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         stat <= '0;
      else
         stat <= (stat & ~({PINS{clr_we}} & clr_mask)) | (cond & sel);
   end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_pkg::*;
#(
   parameter int NUM_BANKS   = 3,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2,
   localparam int TOTAL_PINS = NUM_BANKS * PINS,
   localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [TOTAL_PINS-1:0] pin_in,
   output logic [TOTAL_PINS-1:0] pin_out,
   output logic [TOTAL_PINS-1:0] pin_oe,
   output logic [NUM_BANKS-1:0]  irq
);
   generate
      if (NUM_BANKS < 1 || NUM_BANKS > (1 << BANK_FIELD_W)) begin : g_bad_banks
         $error("gpio_bank_ctrl: NUM_BANKS out of range");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("gpio_bank_ctrl: ADDR_W too small for the register map");
      end
   endgenerate

   logic [REGION_W-1:0] region;
   logic [BANK_W-1:0]   bank;
   alias_e              alias_sel;
   logic                hit;

   gpio_addr_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
      .addr      (bus_addr),
      .region    (region),
      .bank      (bank),
      .alias_sel (alias_sel),
      .hit       (hit)
   );

   logic [PINS-1:0] out_r  [NUM_BANKS];
   logic [PINS-1:0] oe_r   [NUM_BANKS];
   logic [PINS-1:0] sel_r  [NUM_BANKS];
   logic [PINS-1:0] ien_r  [NUM_BANKS];
   logic [PINS-1:0] lvl_r  [NUM_BANKS];
   logic [PINS-1:0] pol_r  [NUM_BANKS];
   logic [PINS-1:0] stat_r [NUM_BANKS];
   logic [PINS-1:0] lev_r  [NUM_BANKS];

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic bank_we;
         assign bank_we = bus_we && hit && (bank == BANK_W'(b));

         gpio_alias_reg #(.W(PINS)) u_out (
            .clk(clk), .rst(rst), .we(bank_we && region == RG_OUT),
            .alias_sel(alias_sel), .wdata(bus_wdata), .q(out_r[b]));
         gpio_alias_reg #(.W(PINS)) u_oe (
            .clk(clk), .rst(rst), .we(bank_we && region == RG_OE),
            .alias_sel(alias_sel), .wdata(bus_wdata), .q(oe_r[b]));
         gpio_alias_reg #(.W(PINS)) u_sel (
            .clk(clk), .rst(rst), .we(bank_we && region == RG_SEL),
            .alias_sel(alias_sel), .wdata(bus_wdata), .q(sel_r[b]));
         gpio_alias_reg #(.W(PINS)) u_ien (
            .clk(clk), .rst(rst), .we(bank_we && region == RG_IEN),
            .alias_sel(alias_sel), .wdata(bus_wdata), .q(ien_r[b]));
         gpio_alias_reg #(.W(PINS)) u_lvl (
            .clk(clk), .rst(rst), .we(bank_we && region == RG_LVL),
            .alias_sel(alias_sel), .wdata(bus_wdata), .q(lvl_r[b]));
         gpio_alias_reg #(.W(PINS)) u_pol (
            .clk(clk), .rst(rst), .we(bank_we && region == RG_POL),
            .alias_sel(alias_sel), .wdata(bus_wdata), .q(pol_r[b]));

         gpio_pin_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
            .clk      (clk),
            .rst      (rst),
            .pin_in   (pin_in[b*PINS +: PINS]),
            .sel      (sel_r[b]),
            .lvl      (lvl_r[b]),
            .pol      (pol_r[b]),
            .clr_we   (bank_we && region == RG_STAT && alias_sel == AL_CLR),
            .clr_mask (bus_wdata),
            .level    (lev_r[b]),
            .stat     (stat_r[b])
         );

         assign pin_out[b*PINS +: PINS] = out_r[b];
         assign pin_oe [b*PINS +: PINS] = oe_r[b];
         assign irq[b] = |(stat_r[b] & ien_r[b]);
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (region)
            RG_OUT:  bus_rdata = out_r[bank];
            RG_IN:   bus_rdata = lev_r[bank];
            RG_OE:   bus_rdata = oe_r[bank];
            RG_SEL:  bus_rdata = sel_r[bank];
            RG_IEN:  bus_rdata = ien_r[bank];
            RG_STAT: bus_rdata = stat_r[bank];
            RG_LVL:  bus_rdata = lvl_r[bank];
            RG_POL:  bus_rdata = pol_r[bank];
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
   import gpio_pkg::*;
#(
   parameter int NUM_BANKS   = 3,
   parameter int ADDR_W      = 12,
   localparam int TOTAL_PINS = NUM_BANKS * PINS
) (
   input logic                  clk,
   input logic                  rst,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic                  bus_we,
   input logic [31:0]           bus_wdata,
   input logic [31:0]           bus_rdata,
   input logic [TOTAL_PINS-1:0] pin_out,
   input logic [TOTAL_PINS-1:0] pin_oe,
   input logic [NUM_BANKS-1:0]  irq
);
   localparam logic [ADDR_W-1:0] A_OUT0_SET = ADDR_W'(12'h004);
   localparam logic [ADDR_W-1:0] A_OUT0_CLR = ADDR_W'(12'h008);
   localparam logic [ADDR_W-1:0] A_OUT0_TOG = ADDR_W'(12'h00C);
   localparam logic [ADDR_W-1:0] A_IEN0     = ADDR_W'(12'h400);

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      rst |=> (pin_out == '0 && pin_oe == '0 && irq == '0));

   // R3
   set_alias_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == A_OUT0_SET) |=>
         pin_out[31:0] == ($past(pin_out[31:0]) | $past(bus_wdata)));

   // R4
   clr_alias_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == A_OUT0_CLR) |=>
         pin_out[31:0] == ($past(pin_out[31:0]) & ~$past(bus_wdata)));

   // R5
   tog_alias_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == A_OUT0_TOG) |=>
         pin_out[31:0] == ($past(pin_out[31:0]) ^ $past(bus_wdata)));

   // R6
   hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
      !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));

   // R11
   irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == A_IEN0 && bus_wdata == '0) |=> !irq[0]);

   // R12
   unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_addr[11:8] > RG_LAST) |-> bus_rdata == '0);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
   .pin_oe(pin_oe), .irq(irq));

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
   localparam int NB = 3;
   localparam int AW = 12;
   localparam int TP = NB * 32;

   logic          clk = 0;
   logic          rst = 1;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [TP-1:0] pin_in = '0;
   logic [TP-1:0] pin_out, pin_oe;
   logic [NB-1:0] irq;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #2.5 clk = ~clk;

   gpio_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) dut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   function automatic logic [AW-1:0] A(int region, int bank, int al);
      return AW'((region << 8) | (bank << 4) | (al << 2));
   endfunction

   // monitor: pops expected read values and compares
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (bus_rdata !== it.exp) begin
            errors++;
            $display("FAIL %s: read got %h expected %h", it.tag, bus_rdata, it.exp);
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_we = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      bus_addr = a;
      it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk); #0.1;
   endtask

   task automatic chk(input logic [95:0] got, input logic [95:0] e, input string tag);
      @(negedge clk);
      checks++;
      if (got !== e) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, e);
      end
   endtask

   task automatic pins(input int idx, input logic v);
      @(posedge clk); #1;
      pin_in[idx] = v;
      repeat (3) @(posedge clk);
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 0;

      // R1 reset state
      chk({pin_out}, 96'd0, "R1 pin_out");
      chk({pin_oe}, 96'd0, "R1 pin_oe");
      chk({93'd0, irq}, 96'd0, "R1 irq");
      rd(A(0, 0, 0), 32'h0, "R1 out reg");

      // R3 R4 R5 aliases on bank 0 output data
      wr(A(0, 0, 0), 32'h0000_00F0);
      wr(A(0, 0, 1), 32'h0000_000F);
      rd(A(0, 0, 0), 32'h0000_00FF, "R3 set alias");
      wr(A(0, 0, 2), 32'h0000_0011);
      rd(A(0, 0, 0), 32'h0000_00EE, "R4 clear alias");
      wr(A(0, 0, 3), 32'hFF00_000F);
      rd(A(0, 0, 0), 32'hFF00_00E1, "R5 toggle alias");
      rd(A(0, 0, 1), 32'hFF00_00E1, "R2 read via set alias");
      rd(A(0, 0, 3), 32'hFF00_00E1, "R2 read via toggle alias");
      chk({64'd0, pin_out[31:0]}, {64'd0, 32'hFF00_00E1}, "R6 pin_out bank0");

      // R6 output enable on bank 2
      wr(A(2, 2, 0), 32'hA5A5_0000);
      chk({64'd0, pin_oe[95:64]}, {64'd0, 32'hA5A5_0000}, "R6 pin_oe bank2");
      chk({64'd0, pin_oe[31:0]}, 96'd0, "R6 pin_oe bank0 untouched");

      // R7 input data
      @(posedge clk); #1;
      pin_in[63:32] = 32'h1234_5678;
      @(posedge clk); @(posedge clk);
      rd(A(1, 1, 0), 32'h1234_5678, "R7 input read");
      wr(A(1, 1, 0), 32'hFFFF_FFFF);
      rd(A(1, 1, 0), 32'h1234_5678, "R7 input write ignored");
      rd(A(5, 1, 0), 32'h0, "R10 no status without select");

      // R8 rising edge on bank0 pin3
      wr(A(3, 0, 1), 32'h0000_0008);
      wr(A(4, 0, 1), 32'h0000_0008);
      wr(A(7, 0, 1), 32'h0000_0008);
      pins(3, 1'b1);
      rd(A(5, 0, 0), 32'h0000_0008, "R8 rising status");
      chk({93'd0, irq}, 96'd1, "R11 irq bank0 set");
      wr(A(5, 0, 2), 32'hFFFF_FFFF);
      rd(A(5, 0, 0), 32'h0, "R10 status cleared");
      chk({93'd0, irq}, 96'd0, "R11 irq bank0 cleared");
      pins(3, 1'b0);
      rd(A(5, 0, 0), 32'h0, "R8 falling ignored in rising mode");

      // R10 set alias on status ignored
      wr(A(5, 0, 1), 32'h0000_FFFF);
      rd(A(5, 0, 0), 32'h0, "R10 status set alias ignored");

      // R9 high level on pin5, clear while level held
      wr(A(6, 0, 1), 32'h0000_0020);
      wr(A(7, 0, 1), 32'h0000_0020);
      wr(A(3, 0, 1), 32'h0000_0020);
      wr(A(4, 0, 1), 32'h0000_0020);
      rd(A(7, 0, 0), 32'h0000_0028, "R2 polarity plane readback");
      pins(5, 1'b1);
      rd(A(5, 0, 0), 32'h0000_0020, "R8 high level status");
      wr(A(5, 0, 2), 32'h0000_0020);
      rd(A(5, 0, 0), 32'h0000_0020, "R9 level re-sets over clear");
      pins(5, 1'b0);
      wr(A(5, 0, 2), 32'h0000_0020);
      rd(A(5, 0, 0), 32'h0, "R9 clear after level gone");

      // R8 R11 falling edge on pin4, enable masked then raised
      wr(A(3, 0, 1), 32'h0000_0010);
      pins(4, 1'b1);
      rd(A(5, 0, 0), 32'h0, "R8 rise ignored in falling mode");
      pins(4, 1'b0);
      rd(A(5, 0, 0), 32'h0000_0010, "R8 falling status");
      chk({93'd0, irq}, 96'd0, "R11 irq masked by enable");
      wr(A(4, 0, 1), 32'h0000_0010);
      chk({93'd0, irq}, 96'd1, "R11 irq after enable set");
      wr(A(5, 0, 2), 32'h0000_0010);
      chk({93'd0, irq}, 96'd0, "R11 irq after clear");

      // R12 unmapped
      rd(A(0, 3, 0), 32'h0, "R12 bank beyond range reads zero");
      wr(A(0, 3, 0), 32'hDEAD_BEEF);
      rd(A(0, 0, 0), 32'hFF00_00E1, "R12 write to bad bank ignored");
      rd(AW'(12'h800), 32'h0, "R12 bad region reads zero");
      wr(AW'(12'h800), 32'h1234_0000);
      chk({pin_out}, {64'd0, 32'hFF00_00E1}, "R12 bad region write ignored");

      repeat (2) @(posedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule